// File: doc/BRIEF.md
# Compare Output Pin Stage

This block is the last stage of one timer compare channel. It keeps a single internal compare-output state bit and changes it whenever a compare-match pulse arrives, or when software issues a force strobe while the timer runs in normal (non-PWM) mode. A 2-bit output mode field picks the action applied to that bit: keep, invert, clear or set. The same mode field also decides who owns the pin value. When the field is zero the general-purpose port latch drives the pin. Any other value hands the pin over to the compare state bit.

The pin direction is never taken over by the block: the port's direction bit alone enables the driver. The mode field is not buffered. A new value is used by the pin multiplexer at once and by the next event on the following clock edge. Changing the waveform kind (PWM or non-PWM) never disturbs the stored state bit. The counter, the comparator and any PWM waveform rules belong to the surrounding timer. All pins are plain level or pulse controls, so no handshake applies.

Top module: `ocp_stage`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, cmp_state is 0.
- R2: With no event in a cycle (match_pulse low, and force_strobe low or pwm_active high), cmp_state holds its value, including across changes of pwm_active and mode_sel.
- R3: With mode_sel = 2'b01, an event inverts cmp_state on the next clock edge.
- R4: With mode_sel = 2'b10, an event makes cmp_state 0 on the next clock edge.
- R5: With mode_sel = 2'b11, an event makes cmp_state 1 on the next clock edge.
- R6: With mode_sel = 2'b00, an event leaves cmp_state unchanged.
- R7: force_strobe with pwm_active low is an event and applies the same action as a match.
- R8: force_strobe with pwm_active high is ignored; cmp_state does not change unless match_pulse is also high.
- R9: match_pulse and an honoured force_strobe in the same cycle apply the action once, so a toggle inverts cmp_state exactly once.
- R10: pin_out equals cmp_state when mode_sel is not 2'b00 and equals port_latch when mode_sel is 2'b00; a change of mode_sel is seen on pin_out in the same cycle, without a clock edge.
- R11: pin_oe equals dir_out in every combination of dir_out and mode_sel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Output mode: 00 disconnected, 01 toggle, 10 clear, 11 set |
| match_pulse | input | 1 | One-cycle compare-match event |
| force_strobe | input | 1 | One-cycle force request |
| pwm_active | input | 1 | High while a PWM waveform mode is selected |
| port_latch | input | 1 | General-purpose port output value |
| dir_out | input | 1 | Port direction bit, 1 = output |
| pin_out | output | 1 | Value offered to the pin driver |
| pin_oe | output | 1 | Pin driver enable; low means high impedance |
| cmp_state | output | 1 | Internal compare-output state bit |

## Verification
The bench goes after a match and a force in the same toggle cycle: a design that treats them as two events inverts twice and leaves the state unchanged. It forces in PWM mode, where a design that forgets the mode check would change the state, and it toggles pwm_active with no events, where a design that clears the state on a mode change would lose it. It rewrites mode_sel between edges and samples pin_out straight away, where a design with a registered mode field would lag one cycle. It also sweeps dir_out against every mode value, where a design that lets the mode field drive the enable would turn on an input pin.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    OCP_KEEP   = 2'b00,
    OCP_TOGGLE = 2'b01,
    OCP_CLEAR  = 2'b10,
    OCP_SET    = 2'b11
  } ocp_act_e;

  function automatic logic ocp_apply(input ocp_act_e act, input logic cur);
    case (act)
      OCP_TOGGLE: ocp_apply = ~cur;
      OCP_CLEAR:  ocp_apply = 1'b0;
      OCP_SET:    ocp_apply = 1'b1;
      default:    ocp_apply = cur;
    endcase
  endfunction

endpackage

// File: rtl/ocp_event_gen.sv
module ocp_event_gen (
  input  logic match_pulse,
  input  logic force_strobe,
  input  logic pwm_active,
  output logic fire
);
  logic force_ok;

  // a force is honoured only outside PWM; merging with OR keeps a coincident
  // match and force as one event
  assign force_ok = force_strobe & ~pwm_active;
  assign fire     = match_pulse | force_ok;
endmodule

// File: rtl/ocp_state_reg.sv
module ocp_state_reg
  import ocp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [MODE_W-1:0] mode_sel,
  output logic              state_q
);
  logic state_d;

  always_comb begin
    state_d = state_q;
    if (fire) state_d = ocp_apply(ocp_act_e'(mode_sel), state_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= 1'b0;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/ocp_pin_mux.sv
module ocp_pin_mux
  import ocp_pkg::*;
(
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              state_q,
  input  logic              port_latch,
  input  logic              dir_out,
  output logic              pin_out,
  output logic              pin_oe
);
  logic takeover;

  assign takeover = |mode_sel;
  assign pin_out  = takeover ? state_q : port_latch;
  assign pin_oe   = dir_out;
endmodule

// File: rtl/ocp_stage.sv
module ocp_stage
  import ocp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              match_pulse,
  input  logic              force_strobe,
  input  logic              pwm_active,
  input  logic              port_latch,
  input  logic              dir_out,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              cmp_state
);
  logic fire;
  logic state_q;

  ocp_event_gen u_evt (
    .match_pulse  (match_pulse),
    .force_strobe (force_strobe),
    .pwm_active   (pwm_active),
    .fire         (fire)
  );

  ocp_state_reg u_st (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .mode_sel (mode_sel),
    .state_q  (state_q)
  );

  ocp_pin_mux u_mux (
    .mode_sel   (mode_sel),
    .state_q    (state_q),
    .port_latch (port_latch),
    .dir_out    (dir_out),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe)
  );

  assign cmp_state = state_q;
endmodule

// File: rtl/ocp_stage_chk.sv
module ocp_stage_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic       match_pulse,
  input logic       force_strobe,
  input logic       pwm_active,
  input logic       port_latch,
  input logic       dir_out,
  input logic       pin_out,
  input logic       pin_oe,
  input logic       cmp_state
);
  logic evt;
  assign evt = match_pulse | (force_strobe & ~pwm_active);

  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (cmp_state == 1'b0));

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(cmp_state));

  assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && mode_sel == 2'b01) |=> (cmp_state != $past(cmp_state)));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && mode_sel == 2'b10) |=> (cmp_state == 1'b0));

  assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && mode_sel == 2'b11) |=> (cmp_state == 1'b1));

  assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00) |=> $stable(cmp_state));

  assert_pwm_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_active && !match_pulse) |=> $stable(cmp_state));

  assert_pin_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pin_out == ((mode_sel != 2'b00) ? cmp_state : port_latch));

  assert_pin_dir_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe == dir_out);
endmodule

bind ocp_stage ocp_stage_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_sel     (mode_sel),
  .match_pulse  (match_pulse),
  .force_strobe (force_strobe),
  .pwm_active   (pwm_active),
  .port_latch   (port_latch),
  .dir_out      (dir_out),
  .pin_out      (pin_out),
  .pin_oe       (pin_oe),
  .cmp_state    (cmp_state)
);

// File: tb/ocp_stage_test.sv
`timescale 1ns/1ps
module ocp_stage_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       match_pulse = 1'b0;
  logic       force_strobe = 1'b0;
  logic       pwm_active = 1'b0;
  logic       port_latch = 1'b0;
  logic       dir_out = 1'b0;
  logic       pin_out, pin_oe, cmp_state;

  int vectors = 0;
  int errors  = 0;
  logic model = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ocp_stage uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .match_pulse(match_pulse),
    .force_strobe(force_strobe), .pwm_active(pwm_active), .port_latch(port_latch),
    .dir_out(dir_out), .pin_out(pin_out), .pin_oe(pin_oe), .cmp_state(cmp_state)
  );

  function automatic logic next_state(logic cur, logic [1:0] m, logic mp, logic fs, logic pw);
    logic ev;
    ev = mp | (fs & ~pw);
    if (!ev) return cur;
    case (m)
      2'b01:   return ~cur;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return cur;
    endcase
  endfunction

  function automatic logic exp_pin(logic st, logic [1:0] m, logic pl);
    return (m != 2'b00) ? st : pl;
  endfunction

  function automatic string state_tag(logic [1:0] m, logic mp, logic fs, logic pw);
    if (mp && fs && !pw) return "R9";
    if (fs && pw && !mp) return "R8";
    if (fs && !pw)       return "R7";
    if (!mp)             return "R2";
    case (m)
      2'b01:   return "R3";
      2'b10:   return "R4";
      2'b11:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  string pending_tag = "R1";

  // drive at negedge, check pins 1ns later, state checked at next negedge
  task automatic step(logic [1:0] m, logic mp, logic fs, logic pw, logic pl, logic d);
    @(negedge clk);
    check(pending_tag, cmp_state, model);
    mode_sel = m; match_pulse = mp; force_strobe = fs;
    pwm_active = pw; port_latch = pl; dir_out = d;
    #1;
    check("R10", pin_out, exp_pin(model, m, pl));
    check("R11", pin_oe, d);
    pending_tag = state_tag(m, mp, fs, pw);
    model = next_state(model, m, mp, fs, pw);
  endtask

  initial begin
    void'($urandom(32'h5eed_0c1a));
    // R1: reset
    repeat (3) @(negedge clk);
    check("R1", cmp_state, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", cmp_state, 1'b0);
    model = 1'b0;

    // directed corners
    step(2'b11, 1, 0, 0, 0, 1);   // R5 set
    step(2'b01, 1, 1, 0, 0, 1);   // R9 single toggle -> 0
    step(2'b11, 0, 1, 1, 1, 1);   // R8 force in PWM ignored
    step(2'b11, 0, 1, 0, 1, 0);   // R7 force sets
    step(2'b00, 0, 0, 1, 0, 1);   // R2 pwm change, state kept
    step(2'b00, 1, 0, 0, 1, 1);   // R6 mode 00 keeps
    step(2'b10, 0, 0, 0, 1, 1);   // R10 immediate source switch
    step(2'b10, 1, 0, 0, 1, 0);   // R4 clear
    step(2'b01, 0, 1, 0, 0, 1);   // R7 toggle via force
    step(2'b01, 1, 0, 1, 0, 1);   // R3 toggle in PWM by match
    for (int d = 0; d < 2; d++)
      for (int m = 0; m < 4; m++)
        for (int p = 0; p < 2; p++)
          step(m[1:0], 0, 0, 0, p[0], d[0]);  // R10 R11 sweep

    // random
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[1:0], r[2] & r[3], r[4] & r[5], r[6], r[7], r[8]);
    end
    @(negedge clk);
    check(pending_tag, cmp_state, model);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        repeat (50000) @(posedge clk);
        if (!done) begin
          vectors++; errors++;
          $display("FAIL watchdog actual=running expected=done");
        end
      end
      wait (done);
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule